// File: doc/BRIEF.md
# Bunch-Tagged Hit Event Memory

This block sits behind a bank of 64 two-threshold discriminators and captures what they saw during a particle-beam train. A free-running crossing counter numbers the bunch crossings from the start of the train. On every crossing where at least one channel fires, the block stores one record. A record holds a hit code for all 64 channels, the crossing number and an 8-bit header byte supplied by the chip. Records fill a 128-entry memory in arrival order. When the last entry is used the block raises a full indication and stops recording.

The full indication is active low and is meant to be wired-AND with the same flag from the other chips on a shared line. The shared line is fed back as an input, so every chip stops together. Between trains a single readout request makes the block unload every stored record over one serial data line, one bit per clock, with a qualifying valid strobe.

The record is 168 bits wide: 8 header bits, 32 tag bits and 128 code bits. No padding is added.

Top module: `hit_event_mem`

## Requirements
- R1: After reset `full_n` is 1, `sdo_valid` is 0 and `sdo` is 0.
- R2: Each channel is stored as a 2-bit code. `00` means no hit. `01` means `hit_lo` only. `11` means `hit_hi` is set, whether or not `hit_lo` is set. `10` is never produced.
- R3: A crossing (`bx_strobe` high for one clock) stores exactly one record, holding all 64 channels, if any `hit_lo` or `hit_hi` bit is set. A crossing with no hit stores nothing.
- R4: Records are serialised oldest first. Within a record the order is: header byte MSB first, then the 32-bit crossing tag MSB first, then channel 0 up to channel 63, each code upper bit first.
- R5: The tag stored with a record is the number of crossings seen since the last `train_start` before that crossing. The first crossing after `train_start` carries tag 0, and crossings that store nothing still advance the count.
- R6: Once 128 records are held, `full_n` is driven low on the next clock and stays low until `train_start`. Further hit crossings store nothing.
- R7: While the shared flag input `ext_full_n` is low, hit crossings store nothing.
- R8: A `rd_start` pulse with N > 0 records stored sets `sdo_valid` from the next clock for exactly N×168 consecutive clocks, one data bit per clock. With no records stored, `rd_start` leaves `sdo_valid` at 0.
- R9: While the unload runs, crossings store nothing but still advance the tag. A further `rd_start` is ignored.
- R10: `train_start` zeroes the tag counter and the record count and releases `full_n`. A `bx_strobe` in the same clock is neither stored nor counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, readout bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| train_start | input | 1 | One-clock pulse at the start of a train |
| bx_strobe | input | 1 | One-clock pulse per bunch crossing |
| hit_lo | input | 64 | Low-threshold discriminator hits, one bit per channel |
| hit_hi | input | 64 | High-threshold discriminator hits, one bit per channel |
| hdr | input | 8 | Header byte stored in each record |
| ext_full_n | input | 1 | Wired-AND full line shared by all chips, active low |
| rd_start | input | 1 | One-clock pulse that starts the serial unload |
| sdo | output | 1 | Serial record data |
| sdo_valid | output | 1 | High while `sdo` carries a record bit |
| full_n | output | 1 | Low when this chip's memory is full |

## Verification
A hit crossing can arrive in the same clock as a serial unload bit. The bench forks a full unload and, twenty clocks into it, drives a hit crossing and a second `rd_start`. It then judges the outcome two ways. First, the stream in progress must match the queued records bit for bit and must not restart. Second, a later unload must show no extra record, and the next recorded tag must have skipped the count consumed during the unload. `train_start` coinciding with `bx_strobe` is provoked the same way and judged from the tag of the next stored record.

// File: rtl/hem_pkg.sv
`timescale 1ns/1ps
package hem_pkg;

   // Unload sequencer states
   typedef enum logic {
      U_IDLE  = 1'b0,
      U_SHIFT = 1'b1
   } unload_state_t;

   // Two thresholds folded into one code; high implies low
   function automatic logic [1:0] hem_code(input logic lo, input logic hi);
      return {hi, lo | hi};
   endfunction

endpackage

// File: rtl/hem_bx_counter.sv
`timescale 1ns/1ps
module hem_bx_counter #(
   parameter int TAG_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             step,
   output logic [TAG_W-1:0] tag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     tag <= '0;
      else if (clear) tag <= '0;
      else if (step)  tag <= tag + 1'b1;   // natural wrap
   end
endmodule

// File: rtl/hem_code_pack.sv
`timescale 1ns/1ps
module hem_code_pack
   import hem_pkg::*;
#(
   parameter int NCH = 64
) (
   input  logic [NCH-1:0]   hit_lo,
   input  logic [NCH-1:0]   hit_hi,
   output logic [2*NCH-1:0] codes,
   output logic             any_hit
);
   // Channel 0 occupies the top two bits so it leaves the shifter first
   for (genvar k = 0; k < NCH; k++) begin : g_ch
      assign codes[2*(NCH-1-k) +: 2] = hem_code(hit_lo[k], hit_hi[k]);
   end
   assign any_hit = |(hit_lo | hit_hi);
endmodule

// File: rtl/hem_store.sv
`timescale 1ns/1ps
module hem_store #(
   parameter int W     = 168,
   parameter int DEPTH = 128,
   parameter int IW    = $clog2(DEPTH),
   parameter int PW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          wr_en,
   input  logic [W-1:0]  wr_data,
   input  logic [IW-1:0] rd_idx,
   output logic [W-1:0]  rd_data,
   output logic [PW-1:0] wptr,
   output logic          full
);
   localparam logic [PW-1:0] LIMIT = PW'(DEPTH);

   logic [W-1:0] mem [DEPTH];

   assign full = (wptr == LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                wptr <= '0;
      else if (clear)            wptr <= '0;
      else if (wr_en && !full)   wptr <= wptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_en && !full && !clear) mem[wptr[IW-1:0]] <= wr_data;
   end

   assign rd_data = mem[rd_idx];
endmodule

// File: rtl/hem_unload.sv
`timescale 1ns/1ps
module hem_unload
   import hem_pkg::*;
#(
   parameter int W     = 168,
   parameter int DEPTH = 128,
   parameter int IW    = $clog2(DEPTH),
   parameter int PW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [PW-1:0] count,
   output logic [IW-1:0] rd_idx,
   input  logic [W-1:0]  rd_data,
   output logic          sdo,
   output logic          busy
);
   localparam int BW = $clog2(W);
   localparam logic [BW-1:0] LAST_BIT = BW'(W - 1);

   unload_state_t state;
   logic [W-1:0]  sh;
   logic [BW-1:0] bitc;
   logic [IW-1:0] rec;
   logic [PW-1:0] total;

   assign busy   = (state == U_SHIFT);
   assign sdo    = busy & sh[W-1];
   assign rd_idx = busy ? IW'(rec + 1'b1) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= U_IDLE;
         sh    <= '0;
         bitc  <= '0;
         rec   <= '0;
         total <= '0;
      end else begin
         unique case (state)
            U_IDLE: begin
               if (start && count != '0) begin
                  sh    <= rd_data;
                  bitc  <= '0;
                  rec   <= '0;
                  total <= count;
                  state <= U_SHIFT;
               end
            end
            U_SHIFT: begin
               if (bitc == LAST_BIT) begin
                  if (PW'(rec) == total - 1'b1) begin
                     state <= U_IDLE;
                     sh    <= '0;
                  end else begin
                     rec  <= rec + 1'b1;
                     sh   <= rd_data;
                     bitc <= '0;
                  end
               end else begin
                  sh   <= {sh[W-2:0], 1'b0};
                  bitc <= bitc + 1'b1;
               end
            end
            default: state <= U_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/hit_event_mem.sv
`timescale 1ns/1ps
module hit_event_mem #(
   parameter int NCH   = 64,
   parameter int DEPTH = 128,
   parameter int TAG_W = 32,
   parameter int HDR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             train_start,
   input  logic             bx_strobe,
   input  logic [NCH-1:0]   hit_lo,
   input  logic [NCH-1:0]   hit_hi,
   input  logic [HDR_W-1:0] hdr,
   input  logic             ext_full_n,
   input  logic             rd_start,
   output logic             sdo,
   output logic             sdo_valid,
   output logic             full_n
);
   localparam int CODE_W = 2;
   localparam int REC_W  = HDR_W + TAG_W + CODE_W * NCH;
   localparam int IW     = $clog2(DEPTH);
   localparam int PW     = $clog2(DEPTH + 1);

   if (NCH < 1)   begin : g_bad_nch   $error("NCH must be at least 1");   end
   if (DEPTH < 2) begin : g_bad_depth $error("DEPTH must be at least 2"); end
   if (TAG_W < 1) begin : g_bad_tag   $error("TAG_W must be at least 1"); end
   if (HDR_W < 1) begin : g_bad_hdr   $error("HDR_W must be at least 1"); end

   logic [TAG_W-1:0]      tag;
   logic [CODE_W*NCH-1:0] codes;
   logic                  any_hit;
   logic [PW-1:0]         wr_ptr;
   logic                  full;
   logic [IW-1:0]         rd_idx;
   logic [REC_W-1:0]      rd_data;
   logic                  busy;
   logic                  wr_en;

   hem_bx_counter #(.TAG_W(TAG_W)) u_bx (
      .clk(clk), .rst_n(rst_n),
      .clear(train_start), .step(bx_strobe & ~train_start),
      .tag(tag)
   );

   hem_code_pack #(.NCH(NCH)) u_pack (
      .hit_lo(hit_lo), .hit_hi(hit_hi),
      .codes(codes), .any_hit(any_hit)
   );

   assign wr_en = bx_strobe & ~train_start & any_hit & ext_full_n & ~busy;

   hem_store #(.W(REC_W), .DEPTH(DEPTH), .IW(IW), .PW(PW)) u_store (
      .clk(clk), .rst_n(rst_n), .clear(train_start),
      .wr_en(wr_en), .wr_data({hdr, tag, codes}),
      .rd_idx(rd_idx), .rd_data(rd_data),
      .wptr(wr_ptr), .full(full)
   );

   hem_unload #(.W(REC_W), .DEPTH(DEPTH), .IW(IW), .PW(PW)) u_unload (
      .clk(clk), .rst_n(rst_n),
      .start(rd_start), .count(wr_ptr),
      .rd_idx(rd_idx), .rd_data(rd_data),
      .sdo(sdo), .busy(busy)
   );

   assign sdo_valid = busy;
   assign full_n    = ~full;
endmodule

// File: rtl/hem_checker.sv
`timescale 1ns/1ps
module hem_checker #(
   parameter int DEPTH = 128,
   parameter int PW    = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          train_start,
   input logic          bx_strobe,
   input logic          any_hit,
   input logic          ext_full_n,
   input logic          rd_start,
   input logic          sdo_valid,
   input logic          full_n,
   input logic [PW-1:0] wr_ptr
);
   p_ptr_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ptr <= PW'(DEPTH));

   p_full_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!full_n && !train_start) |=> !full_n);

   p_nohit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bx_strobe && !any_hit && !train_start) |=> $stable(wr_ptr));

   p_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bx_strobe && any_hit && !train_start && full_n && ext_full_n && !sdo_valid)
      |=> (wr_ptr == $past(wr_ptr) + 1'b1));

   p_ext_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_full_n && !train_start) |=> $stable(wr_ptr));

   p_read_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sdo_valid && !train_start) |=> $stable(wr_ptr));

   p_valid_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sdo_valid) |-> $past(rd_start));

   p_train_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      train_start |=> (wr_ptr == '0 && full_n));
endmodule

bind hit_event_mem hem_checker #(.DEPTH(DEPTH), .PW(PW)) u_chk (
   .clk(clk), .rst_n(rst_n), .train_start(train_start), .bx_strobe(bx_strobe),
   .any_hit(any_hit), .ext_full_n(ext_full_n), .rd_start(rd_start),
   .sdo_valid(sdo_valid), .full_n(full_n), .wr_ptr(wr_ptr)
);

// File: tb/hit_event_mem_tb.sv
`timescale 1ns/1ps
module hit_event_mem_tb;
   localparam int NCH   = 64;
   localparam int DEPTH = 128;
   localparam int REC_W = 8 + 32 + 2 * NCH;

   logic clk = 0, rst_n = 0;
   logic train_start = 0, bx_strobe = 0, ext_full_n = 1, rd_start = 0;
   logic [NCH-1:0] hit_lo = '0, hit_hi = '0;
   logic [7:0] hdr = 8'h00;
   logic sdo, sdo_valid, full_n;

   always #2.5 clk = ~clk;

   hit_event_mem u_dut (
      .clk(clk), .rst_n(rst_n), .train_start(train_start), .bx_strobe(bx_strobe),
      .hit_lo(hit_lo), .hit_hi(hit_hi), .hdr(hdr), .ext_full_n(ext_full_n),
      .rd_start(rd_start), .sdo(sdo), .sdo_valid(sdo_valid), .full_n(full_n)
   );

   int checks = 0, failures = 0, rx_bits = 0;
   bit done = 0, mbusy = 0;
   logic [31:0] mtag = '0;
   logic [REC_W-1:0] mrec[$];
   bit exp_q[$];

   task automatic chk(input bit ok, input string what, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   function automatic logic [REC_W-1:0] mk(input logic [7:0] h, input logic [31:0] t,
                                           input logic [NCH-1:0] lo, input logic [NCH-1:0] hi);
      logic [2*NCH-1:0] c;
      for (int k = 0; k < NCH; k++)
         c[2*NCH-1-2*k -: 2] = hi[k] ? 2'b11 : (lo[k] ? 2'b01 : 2'b00);
      return {h, t, c};
   endfunction

   // Driver: one crossing, model updated from the requirements
   task automatic crossing(input logic [NCH-1:0] lo, input logic [NCH-1:0] hi, input logic [7:0] h);
      @(negedge clk);
      bx_strobe = 1; hit_lo = lo; hit_hi = hi; hdr = h;
      if ((|(lo | hi)) && mrec.size() < DEPTH && ext_full_n && !mbusy)
         mrec.push_back(mk(h, mtag, lo, hi));
      mtag = mtag + 1;
      @(negedge clk);
      bx_strobe = 0; hit_lo = '0; hit_hi = '0;
   endtask

   task automatic train(input bit with_strobe);
      @(negedge clk);
      train_start = 1;
      if (with_strobe) begin bx_strobe = 1; hit_lo = '1; end
      mtag = '0; mrec.delete();
      @(negedge clk);
      train_start = 0; bx_strobe = 0; hit_lo = '0;
   endtask

   task automatic readout();
      int n;
      n = mrec.size();
      @(negedge clk);
      rd_start = 1; rx_bits = 0;
      if (n > 0) begin
         mbusy = 1;
         foreach (mrec[i])
            for (int b = REC_W - 1; b >= 0; b--) exp_q.push_back(mrec[i][b]);
      end
      @(negedge clk);
      rd_start = 0;
      if (n == 0) begin
         for (int i = 0; i < 5; i++) begin
            chk(sdo_valid == 1'b0, "R8 empty unload raised sdo_valid", sdo_valid, 0);
            @(negedge clk);
         end
      end else begin
         while (exp_q.size() > 0) @(negedge clk);
         @(negedge clk);
         chk(sdo_valid == 1'b0, "R8 sdo_valid after last bit", sdo_valid, 0);
         chk(rx_bits == n * REC_W, "R8 unload bit count", rx_bits, n * REC_W);
         mbusy = 0;
      end
   endtask

   // Monitor: pop and compare every valid serial bit
   always @(negedge clk) begin
      if (rst_n && sdo_valid === 1'b1) begin
         rx_bits++;
         if (exp_q.size() == 0) chk(0, "R8 extra serial bit", 1, 0);
         else begin
            bit e;
            e = exp_q.pop_front();
            chk(sdo === e, "R4 serial bit (R2 R3 R5 content)", sdo, e);
         end
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         failures++; checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [NCH-1:0] lo, hi;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(full_n == 1'b1, "R1 full_n at reset", full_n, 1);
      chk(sdo_valid == 1'b0, "R1 sdo_valid at reset", sdo_valid, 0);
      chk(sdo == 1'b0, "R1 sdo at reset", sdo, 0);
      rst_n = 1;
      train(0);
      readout();                                   // R8 empty memory

      // R2 R3 R5: idle crossings advance tag, various code patterns
      crossing('0, '0, 8'h11);
      crossing('0, '0, 8'h12);
      crossing(64'h1, 64'h8000_0000_0000_0000, 8'hA5);   // ch0 low, ch63 high only
      crossing(64'hFFFF_0000_F0F0_1234, 64'h00FF_0000_3300_0004, 8'h3C);
      crossing('0, '0, 8'h13);
      crossing(64'h0, 64'hDEAD_BEEF_0000_0001, 8'hC3);   // high without low -> 11
      readout();                                   // R4 order, oldest first

      // R7 shared full line blocks writes
      ext_full_n = 0;
      crossing('1, '1, 8'h77);
      ext_full_n = 1;
      crossing(64'h2, '0, 8'h78);
      readout();

      // R9 crossing and second rd_start during unload
      fork
         readout();
         begin
            repeat (20) @(negedge clk);
            crossing('1, '0, 8'h99);
            @(negedge clk); rd_start = 1;
            @(negedge clk); rd_start = 0;
         end
      join
      crossing(64'h4, '0, 8'h9A);                  // tag skipped the one consumed in read
      readout();

      // R10 train with simultaneous strobe: not stored, not counted
      train(1);
      chk(full_n == 1'b1, "R10 full_n after train", full_n, 1);
      crossing(64'h8, 64'h8, 8'h01);               // expects tag 0
      readout();

      // R6 fill to capacity
      train(0);
      for (int i = 0; i < DEPTH; i++) begin
         lo = {$urandom(), $urandom()};
         hi = {$urandom(), $urandom()} & {$urandom(), $urandom()};
         lo[i % NCH] = 1'b1;
         crossing(lo, hi, 8'(i));
         if (i == DEPTH - 2) chk(full_n == 1'b1, "R6 full_n one short of full", full_n, 1);
      end
      chk(full_n == 1'b0, "R6 full_n at capacity", full_n, 0);
      crossing('1, '1, 8'hEE);
      crossing('1, '0, 8'hEF);
      chk(full_n == 1'b0, "R6 full_n held", full_n, 0);
      readout();
      train(0);
      chk(full_n == 1'b1, "R10 full released by train", full_n, 1);
      readout();

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule